// File: doc/BRIEF.md
# Camera Receiver Control and Interrupt Register Bank

This block is the register bank of a camera serial receiver. Software reaches it through a simple 32-bit register port. The port has a write strobe, a byte address, write data and a read-data output that follows the address combinationally. The block holds the core enable and a soft-reset request. A countdown makes the reset observable: it raises a busy flag in the core status register, and software polls that flag before it releases the request. Disabling the core runs the same countdown.

The receive datapath reports events as one-cycle pulses. Each pulse sets a sticky bit in the interrupt status register or in a separate error register for virtual channels 4 and up. Software clears these bits by writing one to them. Any nonzero value in the extra-channel error register shows up as a single summary bit in the interrupt status register. That summary bit and the lane-stop bit have no enable and never raise the interrupt. The only other gates on the interrupt are an enable register and a global enable, which together drive one level-sensitive interrupt line.

Top module: `csirx_regbank`

## Requirements
- R1: After synchronous reset, the control, global enable, interrupt status, interrupt enable and extra-channel error registers read zero, the interrupt output is low and the busy flag is low.
- R2: Control register at 0x00: bit 0 is the core enable (drives `core_en_o`) and bit 1 is the soft-reset request (drives `soft_rst_o`). Both read back as written.
- R3: The busy countdown starts on a control write that sets bit 1 while it was 0, or that clears bit 0 while it was 1. Busy (bit 0 of the status register at 0x10, and `dp_rst_o`) then reads one for exactly RST_CYCLES cycles after that write and zero afterwards.
- R4: The status register at 0x10 reads the packet count in bits 31:16, short FIFO full in bit 3, short FIFO not empty in bit 2 and line buffer full in bit 1.
- R5: The lane register at 0x04 reads MAX_LANES-1 in bits 4:3. Bits 1:0 hold the writable active lane count, which drives `act_lanes_o`. All other bits read zero.
- R6: An event pulse on `evt_i` sets the matching interrupt status bit (register at 0x24). Only bits in mask 0x807E3FFF are ever set by events; other bits, bit 30 included, are ignored.
- R7: Writing one to an interrupt status bit clears it. Writing zero leaves the bit unchanged.
- R8: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends set.
- R9: The extra-channel error register at 0x34 (bits 2k for frame level error and 2k+1 for frame sync error of channel k+4) is set by `vcx_evt_i` and cleared by writing one. Interrupt status bit 30 reads one exactly when that register is nonzero. Writing bit 30 of the status register has no effect.
- R10: The interrupt enable register at 0x28 stores only the bits of 0x807C3FFF; bits 30 and 17 always read zero. Global enable is bit 0 at 0x20.
- R11: `irq_o` equals global enable AND the OR of (status AND enable), with no added latency. Status bits 30 and 17 never raise it.
- R12: Writes to unmapped addresses change no register, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_i | input | 32 | Event pulses, one per interrupt status bit |
| vcx_evt_i | input | 2*VCX_CH | Extra-channel error pulses |
| pkt_count_i | input | PKT_CNT_W | Packet count from datapath |
| sfifo_full_i | input | 1 | Short packet FIFO full |
| sfifo_nempty_i | input | 1 | Short packet FIFO not empty |
| lbuf_full_i | input | 1 | Line buffer full |
| core_en_o | output | 1 | Core enable |
| soft_rst_o | output | 1 | Soft reset request |
| dp_rst_o | output | 1 | Reset countdown running (busy) |
| act_lanes_o | output | 2 | Active lane count field |
| irq_o | output | 1 | Level interrupt |

## Verification
Every register updates on the clock edge that samples the write strobe or event pulse. Read data and the interrupt line follow combinationally from that state, so results are due one edge after the stimulus. The busy flag is the exception: it stays high for the RST_CYCLES edges after the starting write. The bench drives inputs on falling edges and samples at the next falling edge, which lands exactly one rising edge after each stimulus. The busy window is checked at its first cycle, its last cycle and the first cycle after it.

// File: rtl/csirx_regs_pkg.sv
`timescale 1ns/1ps
package csirx_regs_pkg;

    localparam logic [15:0] OFS_CTRL = 16'h0000;
    localparam logic [15:0] OFS_LANE = 16'h0004;
    localparam logic [15:0] OFS_STAT = 16'h0010;
    localparam logic [15:0] OFS_GIE  = 16'h0020;
    localparam logic [15:0] OFS_ISR  = 16'h0024;
    localparam logic [15:0] OFS_IER  = 16'h0028;
    localparam logic [15:0] OFS_VCX  = 16'h0034;

    localparam logic [31:0] ISR_VALID    = 32'hC07E3FFF;
    localparam int          VCX_SUM_BIT  = 30;
    localparam int          LANE_STOP_BIT = 17;
    localparam logic [31:0] ISR_EVT_MASK = ISR_VALID & ~(32'h1 << VCX_SUM_BIT);
    localparam logic [31:0] IER_MASK     = ISR_EVT_MASK & ~(32'h1 << LANE_STOP_BIT);

    typedef enum logic [2:0] {
        RS_NONE, RS_CTRL, RS_LANE, RS_STAT, RS_GIE, RS_ISR, RS_IER, RS_VCX
    } reg_sel_e;

    typedef struct packed {
        logic [15:0] pkt_count;
        logic        sfifo_full;
        logic        sfifo_nempty;
        logic        lbuf_full;
        logic        busy;
    } core_stat_t;

    function automatic reg_sel_e decode_addr(input logic [15:0] a);
        case (a)
            OFS_CTRL: return RS_CTRL;
            OFS_LANE: return RS_LANE;
            OFS_STAT: return RS_STAT;
            OFS_GIE:  return RS_GIE;
            OFS_ISR:  return RS_ISR;
            OFS_IER:  return RS_IER;
            OFS_VCX:  return RS_VCX;
            default:  return RS_NONE;
        endcase
    endfunction

    function automatic logic [31:0] pack_status(input core_stat_t s);
        return {s.pkt_count, 12'h000, s.sfifo_full, s.sfifo_nempty, s.lbuf_full, s.busy};
    endfunction

endpackage

// File: rtl/csirx_ctrl.sv
`timescale 1ns/1ps
module csirx_ctrl #(
    parameter int RST_CYCLES = 16,
    parameter int MAX_LANES  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr_i,
    input  logic        lane_wr_i,
    input  logic [31:0] wdata_i,
    output logic        en_o,
    output logic        srst_o,
    output logic        busy_o,
    output logic [1:0]  act_lanes_o,
    output logic [31:0] ctrl_o,
    output logic [31:0] lane_o
);
    localparam int          CNT_W    = $clog2(RST_CYCLES + 1);
    localparam logic [1:0]  MAX_CODE = 2'(MAX_LANES - 1);

    logic             en_q, sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       lanes_q;
    logic             start;

    // countdown starts on a new reset request or on a core disable
    assign start = ctrl_wr_i && ((wdata_i[1] && !sr_q) || (!wdata_i[0] && en_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            sr_q    <= 1'b0;
            cnt_q   <= '0;
            lanes_q <= '0;
        end else begin
            if (ctrl_wr_i) begin
                en_q <= wdata_i[0];
                sr_q <= wdata_i[1];
            end
            if (lane_wr_i)
                lanes_q <= wdata_i[1:0];
            if (start)
                cnt_q <= CNT_W'(RST_CYCLES);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign en_o        = en_q;
    assign srst_o      = sr_q;
    assign busy_o      = (cnt_q != '0);
    assign act_lanes_o = lanes_q;
    assign ctrl_o      = {30'h0, sr_q, en_q};
    assign lane_o      = {27'h0, MAX_CODE, 1'b0, lanes_q};

    // R3
    busy_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_o);

endmodule

// File: rtl/csirx_irq.sv
`timescale 1ns/1ps
module csirx_irq
    import csirx_regs_pkg::*;
#(
    parameter int VCX_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      ev_i,
    input  logic [VCX_W-1:0] vcx_ev_i,
    input  logic             isr_wr_i,
    input  logic             ier_wr_i,
    input  logic             gie_wr_i,
    input  logic             vcx_wr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      isr_o,
    output logic [31:0]      ier_o,
    output logic [31:0]      gie_o,
    output logic [31:0]      vcx_o,
    output logic             irq_o
);
    logic [31:0]      isr_q, ier_q, isr_clr;
    logic [VCX_W-1:0] vcx_q, vcx_clr;
    logic             gie_q;

    assign isr_clr = isr_wr_i ? wdata_i : 32'h0;
    assign vcx_clr = vcx_wr_i ? wdata_i[VCX_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            ier_q <= '0;
            vcx_q <= '0;
            gie_q <= 1'b0;
        end else begin
            // set wins over clear
            isr_q <= (isr_q & ~isr_clr) | (ev_i & ISR_EVT_MASK);
            vcx_q <= (vcx_q & ~vcx_clr) | vcx_ev_i;
            if (ier_wr_i) ier_q <= wdata_i & IER_MASK;
            if (gie_wr_i) gie_q <= wdata_i[0];
        end
    end

    always_comb begin
        isr_o = isr_q;
        isr_o[VCX_SUM_BIT] = |vcx_q;
    end

    assign ier_o = ier_q;
    assign gie_o = {31'h0, gie_q};
    assign vcx_o = 32'(vcx_q);
    assign irq_o = gie_q && |(isr_o & ier_q);

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        isr_wr_i |=> ((isr_q & $past(wdata_i & ~ev_i)) == 32'h0));

    // R8
    evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (|(ev_i & ISR_EVT_MASK)) |=>
            ((isr_q & $past(ev_i & ISR_EVT_MASK)) == $past(ev_i & ISR_EVT_MASK)));

    // R9
    vcx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        vcx_wr_i |=> ((vcx_q & $past(wdata_i[VCX_W-1:0] & ~vcx_ev_i)) == '0));

    // R10
    ier_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        ier_wr_i |=> (!ier_q[VCX_SUM_BIT] && !ier_q[LANE_STOP_BIT]));

endmodule

// File: rtl/csirx_regbank.sv
`timescale 1ns/1ps
module csirx_regbank
    import csirx_regs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int RST_CYCLES = 16,
    parameter int MAX_LANES  = 4,
    parameter int PKT_CNT_W  = 16,
    parameter int VCX_CH     = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [31:0]          evt_i,
    input  logic [2*VCX_CH-1:0]  vcx_evt_i,
    input  logic [PKT_CNT_W-1:0] pkt_count_i,
    input  logic                 sfifo_full_i,
    input  logic                 sfifo_nempty_i,
    input  logic                 lbuf_full_i,
    output logic                 core_en_o,
    output logic                 soft_rst_o,
    output logic                 dp_rst_o,
    output logic [1:0]           act_lanes_o,
    output logic                 irq_o
);
    localparam int VCX_W = 2 * VCX_CH;

    reg_sel_e    sel;
    core_stat_t  stat;
    logic [31:0] ctrl_rd, lane_rd, isr_rd, ier_rd, gie_rd, vcx_rd;
    logic        busy;

    assign sel = decode_addr(16'(reg_addr));

    csirx_ctrl #(.RST_CYCLES(RST_CYCLES), .MAX_LANES(MAX_LANES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr_i  (reg_wr && sel == RS_CTRL),
        .lane_wr_i  (reg_wr && sel == RS_LANE),
        .wdata_i    (reg_wdata),
        .en_o       (core_en_o),
        .srst_o     (soft_rst_o),
        .busy_o     (busy),
        .act_lanes_o(act_lanes_o),
        .ctrl_o     (ctrl_rd),
        .lane_o     (lane_rd)
    );

    csirx_irq #(.VCX_W(VCX_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (evt_i),
        .vcx_ev_i (vcx_evt_i),
        .isr_wr_i (reg_wr && sel == RS_ISR),
        .ier_wr_i (reg_wr && sel == RS_IER),
        .gie_wr_i (reg_wr && sel == RS_GIE),
        .vcx_wr_i (reg_wr && sel == RS_VCX),
        .wdata_i  (reg_wdata),
        .isr_o    (isr_rd),
        .ier_o    (ier_rd),
        .gie_o    (gie_rd),
        .vcx_o    (vcx_rd),
        .irq_o    (irq_o)
    );

    assign dp_rst_o = busy;

    always_comb begin
        stat.pkt_count    = 16'(pkt_count_i);
        stat.sfifo_full   = sfifo_full_i;
        stat.sfifo_nempty = sfifo_nempty_i;
        stat.lbuf_full    = lbuf_full_i;
        stat.busy         = busy;
    end

    always_comb begin
        case (sel)
            RS_CTRL: reg_rdata = ctrl_rd;
            RS_LANE: reg_rdata = lane_rd;
            RS_STAT: reg_rdata = pack_status(stat);
            RS_GIE:  reg_rdata = gie_rd;
            RS_ISR:  reg_rdata = isr_rd;
            RS_IER:  reg_rdata = ier_rd;
            RS_VCX:  reg_rdata = vcx_rd;
            default: reg_rdata = 32'h0;
        endcase
    end

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (gie_rd[0] && ((isr_rd & ier_rd & IER_MASK) != 32'h0)));

endmodule

// File: tb/csirx_regbank_test.sv
`timescale 1ns/1ps
module csirx_regbank_test;
    localparam int RSTC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_i = 32'h0;
    logic [23:0] vcx_evt_i = 24'h0;
    logic [15:0] pkt_count_i = 16'h0;
    logic        sfifo_full_i = 1'b0, sfifo_nempty_i = 1'b0, lbuf_full_i = 1'b0;
    logic        core_en_o, soft_rst_o, dp_rst_o, irq_o;
    logic [1:0]  act_lanes_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    csirx_regbank #(.RST_CYCLES(RSTC)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
        .vcx_evt_i(vcx_evt_i), .pkt_count_i(pkt_count_i),
        .sfifo_full_i(sfifo_full_i), .sfifo_nempty_i(sfifo_nempty_i),
        .lbuf_full_i(lbuf_full_i), .core_en_o(core_en_o),
        .soft_rst_o(soft_rst_o), .dp_rst_o(dp_rst_o),
        .act_lanes_o(act_lanes_o), .irq_o(irq_o)
    );

    // {event, clear, expected status}
    localparam logic [95:0] VEC [5] = '{
        {32'h80000001, 32'h00000000, 32'h80000001},
        {32'hFFFFFFFF, 32'h00000000, 32'h807E3FFF},
        {32'h00003FFF, 32'h00000F0F, 32'h000030F0},
        {32'h3F81C000, 32'h00000000, 32'h00000000},
        {32'h00760000, 32'h00020000, 32'h00740000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] e, input logic [23:0] v);
        @(negedge clk);
        evt_i = e; vcx_evt_i = v;
        @(negedge clk);
        evt_i = 32'h0; vcx_evt_i = 24'h0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, d); check("R1 ctrl", d, 32'h0);
        rd(8'h20, d); check("R1 gie", d, 32'h0);
        rd(8'h24, d); check("R1 isr", d, 32'h0);
        rd(8'h28, d); check("R1 ier", d, 32'h0);
        rd(8'h34, d); check("R1 vcx", d, 32'h0);
        rd(8'h10, d); check("R1 busy", d, 32'h0);
        check("R1 irq", {31'h0, irq_o}, 32'h0);

        // R6 R7 vector walk
        for (int i = 0; i < 5; i++) begin
            wr(8'h24, 32'hFFFFFFFF);
            pulse(VEC[i][95:64], 24'h0);
            wr(8'h24, VEC[i][63:32]);
            rd(8'h24, d);
            check("R6 R7 vector", d, VEC[i][31:0]);
        end

        // R8 event and clear in same cycle
        wr(8'h24, 32'hFFFFFFFF);
        pulse(32'h00000300, 24'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h00000300; evt_i = 32'h00000200;
        @(negedge clk);
        reg_wr = 1'b0; evt_i = 32'h0;
        rd(8'h24, d); check("R8 set wins", d, 32'h00000200);
        wr(8'h24, 32'hFFFFFFFF);

        // R2 R3 control and busy window
        wr(8'h00, 32'h3);
        for (int i = 0; i <= RSTC; i++) begin
            rd(8'h10, d);
            if (i == 0 || i == RSTC - 1 || i == RSTC) begin
                check("R3 busy window", {31'h0, d[0]}, {31'h0, (i < RSTC)});
                check("R3 dp_rst", {31'h0, dp_rst_o}, {31'h0, (i < RSTC)});
            end
            @(negedge clk);
        end
        rd(8'h00, d); check("R2 ctrl readback", d, 32'h3);
        check("R2 outputs", {30'h0, soft_rst_o, core_en_o}, 32'h3);
        wr(8'h00, 32'h1);
        rd(8'h10, d); check("R3 release no busy", {31'h0, d[0]}, 32'h0);
        check("R2 en only", {30'h0, soft_rst_o, core_en_o}, 32'h1);
        wr(8'h00, 32'h0);
        rd(8'h10, d); check("R3 disable busy", {31'h0, d[0]}, 32'h1);
        repeat (RSTC) @(negedge clk);
        rd(8'h10, d); check("R3 disable done", {31'h0, d[0]}, 32'h0);

        // R4 status fields
        pkt_count_i = 16'hABCD; sfifo_full_i = 1'b1; lbuf_full_i = 1'b1;
        rd(8'h10, d); check("R4 status a", d, 32'hABCD000A);
        pkt_count_i = 16'h0001; sfifo_full_i = 1'b0; lbuf_full_i = 1'b0; sfifo_nempty_i = 1'b1;
        rd(8'h10, d); check("R4 status b", d, 32'h00010004);

        // R5 lanes
        wr(8'h04, 32'hFFFFFFFF);
        rd(8'h04, d); check("R5 lanes all", d, 32'h0000001B);
        check("R5 act out", {30'h0, act_lanes_o}, 32'h3);
        wr(8'h04, 32'h2);
        rd(8'h04, d); check("R5 lanes two", d, 32'h0000001A);

        // R9 extra-channel errors
        pulse(32'h0, 24'h000005);
        rd(8'h34, d); check("R9 vcx set", d, 32'h5);
        rd(8'h24, d); check("R9 summary", d, 32'h40000000);
        wr(8'h24, 32'h40000000);
        rd(8'h24, d); check("R9 summary not clearable", d, 32'h40000000);
        wr(8'h34, 32'h1);
        rd(8'h34, d); check("R9 vcx partial clear", d, 32'h4);
        wr(8'h34, 32'h4);
        rd(8'h24, d); check("R9 summary gone", d, 32'h0);

        // R10 R11 enables and interrupt
        wr(8'h28, 32'hFFFFFFFF);
        rd(8'h28, d); check("R10 ier mask", d, 32'h807C3FFF);
        wr(8'h20, 32'h1);
        rd(8'h20, d); check("R10 gie", d, 32'h1);
        pulse(32'h00020000, 24'h0);
        check("R11 lane stop no irq", {31'h0, irq_o}, 32'h0);
        pulse(32'h0, 24'h000001);
        check("R11 summary no irq", {31'h0, irq_o}, 32'h0);
        wr(8'h34, 32'hFFFFFF);
        wr(8'h24, 32'hFFFFFFFF);
        pulse(32'h80000000, 24'h0);
        check("R11 irq raised", {31'h0, irq_o}, 32'h1);
        wr(8'h20, 32'h0);
        check("R11 gie off", {31'h0, irq_o}, 32'h0);
        wr(8'h20, 32'h1);
        check("R11 gie on", {31'h0, irq_o}, 32'h1);
        wr(8'h24, 32'h80000000);
        check("R11 cleared", {31'h0, irq_o}, 32'h0);

        // R12 unmapped
        wr(8'h08, 32'hFFFFFFFF);
        wr(8'h2C, 32'hFFFFFFFF);
        rd(8'h08, d); check("R12 unmapped read", d, 32'h0);
        rd(8'h2C, d); check("R12 unmapped read b", d, 32'h0);
        rd(8'h00, d); check("R12 ctrl untouched", d, 32'h0);
        rd(8'h24, d); check("R12 isr untouched", d, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule